// File: doc/BRIEF.md
# Dual-Bank Cell Histogram Accumulator

This block builds orientation histograms over square pixel cells from a raster stream of quantized gradients. Every clock it may accept one sample made of an orientation bin and a magnitude. It adds the magnitude into the histogram of the cell that holds the current pixel. Raster position is tracked inside the block, and each cell column of the image keeps its own histogram storage.

Updating a synchronous memory needs three steps: form the address, read and add, then write back. A single memory therefore handles one sample every two cycles, but the input never stalls. The block steers successive samples to two separate sub-histogram banks, so each bank sees a new update at most every other cycle. When the last pixel of a cell arrives, a sequencer adds the two banks bin by bin with saturation. It presents the eight results on consecutive cycles and zeroes the entries it has read, so the next cell row in that column starts clean.

The image width must be a multiple of eight and at least 24 pixels. The input stream is continuous over rows, and frame heights are whole multiples of eight rows.

Top module: `cell_hist_acc`

## Requirements
- R1: After reset, `hist_valid` is low and every bin of every cell column starts at zero, so the first histograms contain only samples accepted after reset.
- R2: The bank that takes a sample alternates on every accepted sample, starting with bank 0 after reset. A bank is never read in two consecutive cycles.
- R3: A sample accepted at raster column x and row y belongs to cell column x/8. A cell is complete when the sample with x mod 8 = 7 and y mod 8 = 7 is accepted, and `hist_col` then reports that cell column.
- R4: Each bank bin adds the unsigned magnitude of every sample steered to it. It saturates at 65535 and never wraps.
- R5: Each reported bin count is the sum of the two bank bins, saturated at 65535. This equals min(total magnitude of that bin in the cell, 65535).
- R6: A complete cell is reported as eight consecutive cycles with `hist_valid` high and `hist_bin` counting 0 to 7. `hist_last` is high only on bin 7, and the first bin appears three clock edges after the edge that accepted the completing pixel.
- R7: Reporting a cell clears both banks of that cell column. The cell below starts from zero, and the clearing never coincides with an update to the same column.
- R8: Cycles with `in_valid` low change no histogram, no raster position and no bank choice. Idle gaps anywhere in the stream leave the reported histograms unchanged.
- R9: The block has no back-pressure. A sample is accepted on every cycle in which `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Gradient sample present this cycle |
| in_bin | input | 3 | Orientation bin of the sample |
| in_mag | input | 12 | Unsigned gradient magnitude |
| hist_valid | output | 1 | A combined bin is presented |
| hist_bin | output | 3 | Index of the presented bin |
| hist_col | output | 2 | Cell column of the presented histogram |
| hist_last | output | 1 | Cell-done strobe, high with bin 7 |
| hist_count | output | 16 | Saturated combined count of the bin |

## Verification
On every cycle the assertions check several structural properties. Neither bank is read on two adjacent cycles. A bank write never makes a bin smaller and holds the ceiling once it is reached. The clearing sequencer never touches a column that is being written. A report burst starts at bin 0, steps by one and ends with the strobe on bin 7. Other behaviour shows only in the bench's scenarios, which compare every reported count with totals kept independently per cell: the cell-column mapping, the correct sum of the two banks, saturation at the bank level and in the merge, clearing between cell rows, and immunity to idle gaps.

// File: rtl/cell_hist_pkg.sv
package cell_hist_pkg;
  // Unsigned add clamped to the largest value of a w-bit field (w <= 31).
  function automatic logic [31:0] sat_add(input logic [31:0] a, input logic [31:0] b,
                                          input int unsigned w);
    logic [32:0] s;
    logic [32:0] m;
    s = {1'b0, a} + {1'b0, b};
    m = (33'd1 << w) - 33'd1;
    return (s > m) ? m[31:0] : s[31:0];
  endfunction
endpackage

// File: rtl/cell_hist_raster.sv
module cell_hist_raster #(
  parameter int IMG_W   = 32,
  parameter int CELL_SH = 3,
  parameter int COL_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [COL_W-1:0] cur_col,
  output logic             cell_end
);
  localparam int XW = $clog2(IMG_W);

  logic [XW-1:0]      x_cnt;
  logic [CELL_SH-1:0] row_in_cell;

  assign cur_col  = x_cnt[XW-1:CELL_SH];
  assign cell_end = adv && (&x_cnt[CELL_SH-1:0]) && (&row_in_cell);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_cnt       <= '0;
      row_in_cell <= '0;
    end else if (adv) begin
      if (x_cnt == XW'(IMG_W - 1)) begin
        x_cnt       <= '0;
        row_in_cell <= row_in_cell + 1'b1;
      end else begin
        x_cnt <= x_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cell_hist_bank.sv
module cell_hist_bank
  import cell_hist_pkg::*;
#(
  parameter int COL_W = 2,
  parameter int BIN_W = 3,
  parameter int MAG_W = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [COL_W-1:0] rd_col,
  input  logic [BIN_W-1:0] rd_bin,
  input  logic [MAG_W-1:0] rd_mag,
  input  logic             clr_en,
  input  logic [COL_W-1:0] ro_col,
  input  logic [BIN_W-1:0] ro_bin,
  output logic [CNT_W-1:0] ro_data,
  output logic             wr_en_o,
  output logic [COL_W-1:0] wr_col_o,
  output logic [CNT_W-1:0] wr_old_o,
  output logic [CNT_W-1:0] wr_new_o
);
  localparam int AW    = COL_W + BIN_W;
  localparam int DEPTH = 1 << AW;

  logic [CNT_W-1:0] mem [DEPTH];
  logic             wr_en;
  logic [COL_W-1:0] wr_col;
  logic [BIN_W-1:0] wr_bin;
  logic [MAG_W-1:0] wr_mag;
  logic [CNT_W-1:0] wr_old;
  logic [CNT_W-1:0] wr_new;
  logic [31:0]      sum32;

  always_comb begin
    sum32  = sat_add(32'(wr_old), 32'(wr_mag), CNT_W);
    wr_new = sum32[CNT_W-1:0];
  end

  assign ro_data  = mem[{ro_col, ro_bin}];
  assign wr_en_o  = wr_en;
  assign wr_col_o = wr_col;
  assign wr_old_o = wr_old;
  assign wr_new_o = wr_new;

  // Cycle 1: read old count; cycle 2: write the sum back.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en  <= 1'b0;
      wr_col <= '0;
      wr_bin <= '0;
      wr_mag <= '0;
      wr_old <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      wr_en <= rd_en;
      if (rd_en) begin
        wr_col <= rd_col;
        wr_bin <= rd_bin;
        wr_mag <= rd_mag;
        wr_old <= mem[{rd_col, rd_bin}];
      end
      if (wr_en)  mem[{wr_col, wr_bin}] <= wr_new;
      if (clr_en) mem[{ro_col, ro_bin}] <= '0;
    end
  end
endmodule

// File: rtl/cell_hist_merge.sv
module cell_hist_merge
  import cell_hist_pkg::*;
#(
  parameter int COL_W = 2,
  parameter int BIN_W = 3,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [CNT_W-1:0] b0_data,
  input  logic [CNT_W-1:0] b1_data,
  output logic             ro_active,
  output logic [COL_W-1:0] ro_col,
  output logic [BIN_W-1:0] ro_bin,
  output logic             hist_valid,
  output logic [BIN_W-1:0] hist_bin,
  output logic [COL_W-1:0] hist_col,
  output logic             hist_last,
  output logic [CNT_W-1:0] hist_count
);
  logic [31:0]      sum32;
  logic [CNT_W-1:0] merged;
  logic             at_end;

  always_comb begin
    sum32  = sat_add(32'(b0_data), 32'(b1_data), CNT_W);
    merged = sum32[CNT_W-1:0];
  end
  assign at_end = &ro_bin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ro_active  <= 1'b0;
      ro_col     <= '0;
      ro_bin     <= '0;
      hist_valid <= 1'b0;
      hist_bin   <= '0;
      hist_col   <= '0;
      hist_last  <= 1'b0;
      hist_count <= '0;
    end else begin
      if (start) begin
        ro_active <= 1'b1;
        ro_col    <= start_col;
        ro_bin    <= '0;
      end else if (ro_active) begin
        ro_bin <= ro_bin + 1'b1;
        if (at_end) ro_active <= 1'b0;
      end
      hist_valid <= ro_active;
      if (ro_active) begin
        hist_bin   <= ro_bin;
        hist_col   <= ro_col;
        hist_last  <= at_end;
        hist_count <= merged;
      end else begin
        hist_last <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cell_hist_acc.sv
module cell_hist_acc #(
  parameter int IMG_W = 32,
  parameter int CELL  = 8,
  parameter int NBINS = 8,
  parameter int MAG_W = 12,
  parameter int CNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [$clog2(NBINS)-1:0] in_bin,
  input  logic [MAG_W-1:0]         in_mag,
  output logic                     hist_valid,
  output logic [$clog2(NBINS)-1:0] hist_bin,
  output logic [$clog2(IMG_W)-$clog2(CELL)-1:0] hist_col,
  output logic                     hist_last,
  output logic [CNT_W-1:0]         hist_count
);
  localparam int BIN_W   = $clog2(NBINS);
  localparam int CELL_SH = $clog2(CELL);
  localparam int COL_W   = $clog2(IMG_W) - CELL_SH;

  logic [COL_W-1:0] cur_col;
  logic             cell_end;
  logic             bank_q;
  logic             s1_valid, s1_bank, s1_done;
  logic [COL_W-1:0] s1_col;
  logic [BIN_W-1:0] s1_bin;
  logic [MAG_W-1:0] s1_mag;
  logic             s2_done;
  logic [COL_W-1:0] s2_col;
  logic             ro_active;
  logic [COL_W-1:0] ro_col;
  logic [BIN_W-1:0] ro_bin;

  logic [1:0]            bk_rd_en;
  logic [1:0]            bk_wr_en;
  logic [1:0][COL_W-1:0] bk_wr_col;
  logic [1:0][CNT_W-1:0] bk_wr_old;
  logic [1:0][CNT_W-1:0] bk_wr_new;
  logic [1:0][CNT_W-1:0] bk_ro_data;

  cell_hist_raster #(.IMG_W(IMG_W), .CELL_SH(CELL_SH), .COL_W(COL_W)) u_raster (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .cur_col(cur_col), .cell_end(cell_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q   <= 1'b0;
      s1_valid <= 1'b0;
      s1_bank  <= 1'b0;
      s1_done  <= 1'b0;
      s1_col   <= '0;
      s1_bin   <= '0;
      s1_mag   <= '0;
      s2_done  <= 1'b0;
      s2_col   <= '0;
    end else begin
      if (in_valid) bank_q <= ~bank_q;
      s1_valid <= in_valid;
      s1_done  <= cell_end;
      if (in_valid) begin
        s1_bank <= bank_q;
        s1_col  <= cur_col;
        s1_bin  <= in_bin;
        s1_mag  <= in_mag;
      end
      s2_done <= s1_done;
      s2_col  <= s1_col;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign bk_rd_en[b] = s1_valid && (s1_bank == 1'(b));
    cell_hist_bank #(.COL_W(COL_W), .BIN_W(BIN_W), .MAG_W(MAG_W), .CNT_W(CNT_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .rd_en(bk_rd_en[b]), .rd_col(s1_col), .rd_bin(s1_bin), .rd_mag(s1_mag),
      .clr_en(ro_active), .ro_col(ro_col), .ro_bin(ro_bin), .ro_data(bk_ro_data[b]),
      .wr_en_o(bk_wr_en[b]), .wr_col_o(bk_wr_col[b]),
      .wr_old_o(bk_wr_old[b]), .wr_new_o(bk_wr_new[b])
    );
  end

  cell_hist_merge #(.COL_W(COL_W), .BIN_W(BIN_W), .CNT_W(CNT_W)) u_merge (
    .clk(clk), .rst_n(rst_n),
    .start(s2_done), .start_col(s2_col),
    .b0_data(bk_ro_data[0]), .b1_data(bk_ro_data[1]),
    .ro_active(ro_active), .ro_col(ro_col), .ro_bin(ro_bin),
    .hist_valid(hist_valid), .hist_bin(hist_bin), .hist_col(hist_col),
    .hist_last(hist_last), .hist_count(hist_count)
  );
endmodule

// File: rtl/cell_hist_acc_chk.sv
module cell_hist_acc_chk #(
  parameter int COL_W = 2,
  parameter int BIN_W = 3,
  parameter int CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            bk_rd_en,
  input logic [1:0]            bk_wr_en,
  input logic [1:0][COL_W-1:0] bk_wr_col,
  input logic [1:0][CNT_W-1:0] bk_wr_old,
  input logic [1:0][CNT_W-1:0] bk_wr_new,
  input logic                  ro_active,
  input logic [COL_W-1:0]      ro_col,
  input logic                  hist_valid,
  input logic [BIN_W-1:0]      hist_bin,
  input logic                  hist_last
);
  localparam logic [CNT_W-1:0] TOP = '1;

  p_bank0_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bk_rd_en[0] |=> !bk_rd_en[0]);
  p_bank1_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bk_rd_en[1] |=> !bk_rd_en[1]);
  p_one_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bk_rd_en));

  p_no_wrap0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bk_wr_en[0] |-> bk_wr_new[0] >= bk_wr_old[0]);
  p_no_wrap1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bk_wr_en[1] |-> bk_wr_new[1] >= bk_wr_old[1]);
  p_hold_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_wr_en[0] && bk_wr_old[0] == TOP) |-> bk_wr_new[0] == TOP);

  p_first_bin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hist_valid) |-> hist_bin == '0);
  p_step_bin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_valid && !hist_last) |=> hist_valid && hist_bin == $past(hist_bin) + 1'b1);
  p_last_bin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_valid && hist_last) |-> (&hist_bin));

  p_no_clash0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ro_active && bk_wr_en[0]) |-> bk_wr_col[0] != ro_col);
  p_no_clash1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ro_active && bk_wr_en[1]) |-> bk_wr_col[1] != ro_col);
endmodule

bind cell_hist_acc cell_hist_acc_chk #(.COL_W(COL_W), .BIN_W(BIN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .bk_rd_en(bk_rd_en), .bk_wr_en(bk_wr_en), .bk_wr_col(bk_wr_col),
  .bk_wr_old(bk_wr_old), .bk_wr_new(bk_wr_new),
  .ro_active(ro_active), .ro_col(ro_col),
  .hist_valid(hist_valid), .hist_bin(hist_bin), .hist_last(hist_last)
);

// File: tb/sim_cell_hist_acc.sv
module sim_cell_hist_acc;
  localparam int IMG_W = 32;
  localparam int NCOL  = 4;
  localparam int NB    = 8;
  localparam int CMAX  = 65535;

  typedef struct {
    int    col;
    int    bin;
    int    cnt;
    bit    last;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_bin = '0;
  logic [11:0] in_mag = '0;
  logic        hist_valid;
  logic [2:0]  hist_bin;
  logic [1:0]  hist_col;
  logic        hist_last;
  logic [15:0] hist_count;

  exp_t sbq[$];
  int   acc[NCOL][NB];
  int   row_g = 0;
  int   vectors = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  cell_hist_acc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bin(in_bin), .in_mag(in_mag),
    .hist_valid(hist_valid), .hist_bin(hist_bin), .hist_col(hist_col),
    .hist_last(hist_last), .hist_count(hist_count)
  );

  function automatic int pat_bin(int p, int x, int y);
    case (p)
      0: return ((x / 8) + (y / 8)) % 8;
      1: return (x * 5 + y * 3) % 8;
      2: return 2;
      default: return 5;
    endcase
  endfunction

  function automatic int pat_mag(int p, int x, int y);
    case (p)
      0: return 1 + (x % 8) + (y % 8);
      1: return (x * 37 + y * 91 + 11) % 4096;
      2: return 4095;
      default: return 2000;
    endcase
  endfunction

  // Driver: feed whole rows and push the expected combined histograms.
  task automatic feed(int p, int rows, int gap, string tag);
    for (int r = 0; r < rows; r++) begin
      for (int x = 0; x < IMG_W; x++) begin
        if (gap > 0 && ((x + r) % 3 == 0)) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_bin   = 3'd7;
          in_mag   = 12'hfff;
          repeat (gap - 1) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_bin   = 3'(pat_bin(p, x, row_g));
        in_mag   = 12'(pat_mag(p, x, row_g));
        acc[x / 8][pat_bin(p, x, row_g)] += pat_mag(p, x, row_g);
        if ((x % 8 == 7) && (row_g % 8 == 7)) begin
          for (int b = 0; b < NB; b++) begin
            exp_t e;
            e.col  = x / 8;
            e.bin  = b;
            e.cnt  = (acc[x / 8][b] > CMAX) ? CMAX : acc[x / 8][b];
            e.last = (b == NB - 1);
            e.tag  = tag;
            sbq.push_back(e);
            acc[x / 8][b] = 0;
          end
        end
      end
      row_g++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: compare each presented bin with the oldest expected item.
  always @(negedge clk) begin
    if (rst_n && hist_valid) begin
      vectors++;
      if (sbq.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected output: actual col=%0d bin=%0d cnt=%0d expected none",
                 hist_col, hist_bin, hist_count);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        if (hist_col != 2'(e.col) || hist_bin != 3'(e.bin) ||
            hist_count != 16'(e.cnt) || hist_last != e.last) begin
          errors++;
          $display("FAIL %s: actual col=%0d bin=%0d cnt=%0d last=%0d expected col=%0d bin=%0d cnt=%0d last=%0d",
                   e.tag, hist_col, hist_bin, hist_count, hist_last,
                   e.col, e.bin, e.cnt, e.last);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < NCOL; c++)
      for (int b = 0; b < NB; b++) acc[c][b] = 0;
    repeat (4) @(negedge clk);
    vectors++;
    if (hist_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 hist_valid during reset: actual=%b expected=0", hist_valid);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    vectors++;
    if (hist_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 hist_valid after reset: actual=%b expected=0", hist_valid);
    end
    feed(0, 16, 0, "R1 R3 cell mapping");
    feed(1, 16, 0, "R2 R5 R7 mixed pattern");
    feed(2, 8,  0, "R4 bank saturation");
    feed(3, 8,  0, "R5 merge saturation");
    feed(1, 16, 2, "R8 R9 idle gaps");
    feed(0, 8,  1, "R6 R7 back-to-back cells");
    repeat (30) @(negedge clk);
    vectors++;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL R6 missing outputs: actual pending=%0d expected 0", sbq.size());
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog expired: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule